// File: doc/BRIEF.md
# 64K x 1 Asynchronous SRAM Controller

This block sits between a clocked host and an external static RAM of 65,536 one-bit words that has a data-in pin and a separate data-out pin. The host asks for one access at a time with a single-cycle strobe. The request carries a direction, a 16-bit word address and, for writes, one data bit. The controller produces the active-low chip-enable and write-enable waveforms, drives the address and the data-in pin, and captures the data-out pin at the right cycle of a read.

All memory timing is set by integer parameters counted in clock cycles. `T_WP` is the write pulse length and `T_DS` is the data setup before the end of the pulse. `T_AA` is the read access time and `T_RC` is the minimum start-to-start spacing. A write is closed by raising write-enable while chip-enable is still low. Chip-enable is released after every access, so the memory rests in standby whenever the host is quiet.

A hold input lets the host keep the controller off the memory while the supply is lowered for data retention. After the hold is removed, a further recovery window of `T_RC` cycles must pass before any access can start.

Top module: `sram64k1_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mem_ce_n` and `mem_we_n` are 1, and `mem_d`, `busy` and `rd_valid` are 0.
- R2: A request is taken only on a clock edge where `req` is 1 and both `busy` and `ret_hold` are 0. A request presented while `busy` is 1 has no effect on the memory or on the outputs.
- R3: For each write, `mem_we_n` is 0 for exactly max(`T_WP`, `T_DS`) consecutive cycles, and `mem_ce_n` is 0 for the whole pulse. `mem_we_n` returns to 1 while `mem_ce_n` is still 0.
- R4: While `mem_we_n` is 0, `mem_addr` and `mem_d` do not change. `mem_d` equals the `req_wdata` bit given with the request.
- R5: A read holds `mem_ce_n` at 0 and `mem_we_n` at 1 for `T_AA` cycles. `rd_data` is the value of `mem_q` at the edge that ends the last of those cycles. `rd_valid` is 1 for exactly the one cycle after that edge.
- R6: `mem_we_n` is never 0 while `mem_ce_n` is 1. `rd_valid` never follows a write access.
- R7: Before each access starts, `mem_ce_n` is 1 for at least one cycle. With no request pending, `mem_ce_n` stays at 1.
- R8: Two consecutive accepted requests are at least `T_RC` clock edges apart.
- R9: While `ret_hold` is 1, no request is taken and `mem_ce_n` stays 1 once any current access has finished. After `ret_hold` falls, `busy` stays 1 for exactly `T_RC` further cycles.
- R10: `mem_addr` is constant for as long as `mem_ce_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Single-cycle access request |
| req_we | input | 1 | 1 selects a write, 0 selects a read |
| req_addr | input | 16 | Word address of the request |
| req_wdata | input | 1 | Bit to be written |
| ret_hold | input | 1 | Data-retention hold; its falling edge starts the recovery window |
| busy | output | 1 | 1 while a new request would be refused |
| rd_valid | output | 1 | One-cycle strobe marking captured read data |
| rd_data | output | 1 | Captured read bit |
| mem_addr | output | 16 | Address to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_d | output | 1 | Data-in pin of the memory |
| mem_q | input | 1 | Data-out pin of the memory |

## Verification
The assertions assume the host follows the request protocol: inputs are steady around the clock edge, and `req` is only treated as taken when `busy` and `ret_hold` are both low. The spacing and pulse-length checks also count from a reset that the host applied cleanly. The stimulus drives every input at the falling clock edge. The driver waits for `busy` to drop before it raises `req`, except in one deliberate case where a request is offered while `busy` is high. The bench memory model returns an inverted bit until `T_AA` read cycles have passed on a stable address, so a capture made too early is caught by the scoreboard.

// File: rtl/sram64k1_pkg.sv
// Shared types for the 64K x 1 SRAM controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sram64k1_pkg;

    // Access phase of the memory-facing sequencer.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,  // chip disabled, nothing pending
        PH_WPULSE = 3'd1,  // write-enable low, chip-enable low
        PH_WEND   = 3'd2,  // write-enable raised, chip-enable still low
        PH_READ   = 3'd3,  // chip-enable low for the access time
        PH_GAP    = 3'd4   // first standby cycle after an access
    } phase_t;

endpackage

// File: rtl/sram64k1_req_capture.sv
// Request capture: registers the address, direction and write bit when a
// request is accepted and holds them until the next acceptance.
// Assumes: take is a single-cycle pulse that is only raised when the
// sequencer is free, so the held values never change mid-access.
module sram64k1_req_capture #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              in_we,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_wdata,
    output logic              held_we,
    output logic [ADDR_W-1:0] held_addr,
    output logic              held_wdata
);

    // Latch the request fields on acceptance; the write bit only on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_we    <= 1'b0;
            held_addr  <= '0;
            held_wdata <= 1'b0;
        end else if (take) begin
            held_we   <= in_we;
            held_addr <= in_addr;
            if (in_we) begin
                held_wdata <= in_wdata;
            end
        end
    end

endmodule

// File: rtl/sram64k1_phase_fsm.sv
// Phase sequencer: produces the chip-enable and write-enable waveforms of
// one access, and the strobe marking the cycle whose closing edge samples
// read data.
// Assumes: start is only raised while free is 1; WP_LEN and T_AA are >= 1.
module sram64k1_phase_fsm
    import sram64k1_pkg::*;
#(
    parameter int WP_LEN = 1,
    parameter int T_AA   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_we,
    output logic ce_n,
    output logic we_n,
    output logic sample,
    output logic free
);

    localparam int LONGEST = (WP_LEN > T_AA) ? WP_LEN : T_AA;
    localparam int CNT_W   = $clog2(LONGEST + 1);
    localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_LEN - 1);
    localparam logic [CNT_W-1:0] AA_LOAD = CNT_W'(T_AA - 1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    // Advance the phase and its cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE, PH_GAP: begin
                    if (start) begin
                        phase <= start_we ? PH_WPULSE : PH_READ;
                        cnt   <= start_we ? WP_LOAD : AA_LOAD;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                PH_WPULSE: begin
                    if (cnt == '0) begin
                        phase <= PH_WEND;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_WEND: begin
                    phase <= PH_GAP;
                end
                PH_READ: begin
                    if (cnt == '0) begin
                        phase <= PH_GAP;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    // Decode the memory strobes and status flags from the phase.
    always_comb begin
        ce_n   = !((phase == PH_WPULSE) || (phase == PH_WEND) || (phase == PH_READ));
        we_n   = (phase != PH_WPULSE);
        sample = (phase == PH_READ) && (cnt == '0);
        free   = (phase == PH_IDLE) || (phase == PH_GAP);
    end

endmodule

// File: rtl/sram64k1_pace_gate.sv
// Pacing gate: enforces the minimum start-to-start spacing and the
// recovery window that follows a data-retention hold.
// Assumes: T_RC >= 1; start is a single-cycle pulse.
module sram64k1_pace_gate #(
    parameter int T_RC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    output logic ready
);

    localparam int PW = $clog2(T_RC + 1);
    localparam logic [PW-1:0] SP_LOAD  = PW'(T_RC - 1);
    localparam logic [PW-1:0] REC_LOAD = PW'(T_RC);

    logic [PW-1:0] spacing;
    logic [PW-1:0] recover;

    // Count down the spacing left since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spacing <= '0;
        end else if (start) begin
            spacing <= SP_LOAD;
        end else if (spacing != '0) begin
            spacing <= spacing - 1'b1;
        end
    end

    // Reload recovery during the hold, then count the window after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recover <= '0;
        end else if (hold) begin
            recover <= REC_LOAD;
        end else if (recover != '0) begin
            recover <= recover - 1'b1;
        end
    end

    // Both windows must have run out.
    always_comb begin
        ready = (spacing == '0) && (recover == '0);
    end

endmodule

// File: rtl/sram64k1_rd_capture.sv
// Read capture: takes the memory output bit at the sampling edge and
// raises a one-cycle valid strobe beside it.
// Assumes: sample is high for only one cycle per read.
module sram64k1_rd_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic q_in,
    output logic rd_valid,
    output logic rd_data
);

    // Register the sampled bit and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 1'b0;
        end else begin
            rd_valid <= sample;
            if (sample) begin
                rd_data <= q_in;
            end
        end
    end

endmodule

// File: rtl/sram64k1_ctrl.sv
// Top of the 64K x 1 asynchronous SRAM controller. It accepts single-cycle
// host requests, runs one memory access at a time, and paces accesses to
// the cycle-count timing parameters.
// Assumes: the host samples busy before raising req; mem_q is only
// meaningful while the memory is read-enabled.
module sram64k1_ctrl #(
    parameter int ADDR_W = 16,
    parameter int T_WP   = 1,
    parameter int T_DS   = 1,
    parameter int T_AA   = 1,
    parameter int T_RC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wdata,
    input  logic              ret_hold,
    output logic              busy,
    output logic              rd_valid,
    output logic              rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_d,
    input  logic              mem_q
);

    localparam int WP_LEN = (T_WP > T_DS) ? T_WP : T_DS;

    logic accept;
    logic seq_free;
    logic pace_ready;
    logic do_sample;
    logic held_we;

    // Acceptance and the busy flag shown to the host.
    always_comb begin
        busy   = !(seq_free && pace_ready);
        accept = req && !busy && !ret_hold;
    end

    sram64k1_req_capture #(
        .ADDR_W (ADDR_W)
    ) cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (accept),
        .in_we      (req_we),
        .in_addr    (req_addr),
        .in_wdata   (req_wdata),
        .held_we    (held_we),
        .held_addr  (mem_addr),
        .held_wdata (mem_d)
    );

    sram64k1_phase_fsm #(
        .WP_LEN (WP_LEN),
        .T_AA   (T_AA)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_we (req_we),
        .ce_n     (mem_ce_n),
        .we_n     (mem_we_n),
        .sample   (do_sample),
        .free     (seq_free)
    );

    sram64k1_pace_gate #(
        .T_RC (T_RC)
    ) pace_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .hold  (ret_hold),
        .ready (pace_ready)
    );

    sram64k1_rd_capture rdc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (do_sample && !held_we),
        .q_in     (mem_q),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/sram64k1_ctrl_chk.sv
// Protocol checker for the SRAM controller, bound to the top module.
// Assumes: reset is asserted from time zero; inputs are steady at edges.
module sram64k1_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int T_WP   = 1,
    parameter int T_DS   = 1,
    parameter int T_AA   = 1,
    parameter int T_RC   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ret_hold,
    input logic              busy,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_d
);

    localparam int WP_LEN = (T_WP > T_DS) ? T_WP : T_DS;
    localparam int LW     = $clog2(WP_LEN + 2) + 1;
    localparam int SW     = $clog2(T_RC + 1) + 1;

    logic          taken;
    logic [LW-1:0] low_run;
    logic [SW-1:0] since_take;
    logic          prev_we_n;

    always_comb taken = req && !busy && !ret_hold;

    // Track the current write-enable low run length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run   <= '0;
            prev_we_n <= 1'b1;
        end else begin
            prev_we_n <= mem_we_n;
            if (!mem_we_n) begin
                if (low_run != '1) low_run <= low_run + 1'b1;
            end else begin
                low_run <= '0;
            end
        end
    end

    // Count edges since the last accepted request, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_take <= SW'(T_RC);
        end else if (taken) begin
            since_take <= '0;
        end else if (since_take < SW'(T_RC)) begin
            since_take <= since_take + 1'b1;
        end
    end

    // R3: the pulse ends with exactly the expected length
    a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && !prev_we_n) |-> (low_run == LW'(WP_LEN)));

    // R3: write-enable rises while chip-enable is held low
    a_r3_we_rise_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_ce_n);

    // R4: address steady through the pulse
    a_r4_addr_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    // R4: data steady through the pulse
    a_r4_data_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_d));

    // R5: valid strobe lasts one cycle
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6: no write strobe without chip enable
    a_r6_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // R6: read data never follows a write cycle
    a_r6_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_we_n));

    // R7: every access starts from a standby cycle
    a_r7_start_from_standby: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> mem_ce_n);

    // R8: accepted requests are spaced by at least T_RC edges
    a_r8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (since_take >= SW'(T_RC - 1)));

    // R9: a hold keeps the controller busy in the following cycle
    a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ret_hold |=> busy);

    // R10: address steady while chip-enable stays low
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram64k1_ctrl sram64k1_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .T_WP   (T_WP),
    .T_DS   (T_DS),
    .T_AA   (T_AA),
    .T_RC   (T_RC)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .ret_hold (ret_hold),
    .busy     (busy),
    .rd_valid (rd_valid),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_d    (mem_d)
);

// File: tb/sram64k1_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for the SRAM controller with a behavioural memory model.
module sram64k1_ctrl_tb_top;

    localparam int P_WP  = 3;
    localparam int P_DS  = 2;
    localparam int P_AA  = 2;
    localparam int P_RC  = 5;
    localparam int WPL   = (P_WP > P_DS) ? P_WP : P_DS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_wdata = 1'b0;
    logic        ret_hold = 1'b0;
    logic        busy, rd_valid, rd_data;
    logic [15:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_d;
    logic        mem_q = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int ncyc = 0;
    int n_acc = 0;
    int last_acc = -1;
    int wl = 0;
    int acc_cnt = 0;
    logic [15:0] acc_addr = '0;
    logic [15:0] p_addr = '0;
    logic        p_d = 1'b0;
    logic        last_wd = 1'b0;
    logic        prev_ce_n = 1'b1;
    logic [15:0] prev_addr = '0;
    logic        prev_valid = 1'b0;
    bit          mon_on = 1'b0;
    bit          done = 1'b0;

    bit mem_arr [int];
    bit shadow [int];
    bit exp_q [$];

    always #10 clk = ~clk;

    sram64k1_ctrl #(
        .ADDR_W (16), .T_WP (P_WP), .T_DS (P_DS), .T_AA (P_AA), .T_RC (P_RC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .req (req), .req_we (req_we),
        .req_addr (req_addr), .req_wdata (req_wdata), .ret_hold (ret_hold),
        .busy (busy), .rd_valid (rd_valid), .rd_data (rd_data),
        .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_we_n (mem_we_n),
        .mem_d (mem_d), .mem_q (mem_q)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", rq, act, expv, ncyc);
        end
    endtask

    function automatic bit peek(input bit arr [int], input int a);
        return arr.exists(a) ? arr[a] : 1'b0;
    endfunction

    // Memory model: a write lands when write-enable rises under chip-enable.
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_ce_n) mem_arr[int'(mem_addr)] = mem_d;
    end

    // Memory model: output is correct only after T_AA read cycles on one address.
    always @(negedge clk) begin
        if (!mem_ce_n && mem_we_n) begin
            acc_cnt = (acc_cnt > 0 && mem_addr == acc_addr) ? acc_cnt + 1 : 1;
        end else begin
            acc_cnt = 0;
        end
        acc_addr = mem_addr;
        mem_q <= (acc_cnt >= P_AA) ? peek(mem_arr, int'(mem_addr))
                                   : ~peek(mem_arr, int'(mem_addr));
    end

    // Monitor: protocol checks and scoreboard pops at the falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            ncyc++;
            if (req && !busy && !ret_hold) begin
                chk(mem_ce_n == 1'b1, "R7 standby before start", mem_ce_n, 1);
                if (last_acc >= 0) chk(ncyc - last_acc >= P_RC, "R8 spacing", ncyc - last_acc, P_RC);
                last_acc = ncyc;
                n_acc++;
            end
            if (!mem_we_n) begin
                wl++;
                chk(!mem_ce_n, "R6 we low needs ce low", mem_ce_n, 0);
                if (wl == 1) begin
                    p_addr = mem_addr;
                    p_d = mem_d;
                    chk(mem_d == last_wd, "R4 data bit", mem_d, last_wd);
                end else begin
                    chk(mem_addr == p_addr, "R4 addr in pulse", mem_addr, p_addr);
                    chk(mem_d == p_d, "R4 data in pulse", mem_d, p_d);
                end
            end else if (wl > 0) begin
                chk(wl == WPL, "R3 pulse length", wl, WPL);
                chk(!mem_ce_n, "R3 ce low at we rise", mem_ce_n, 0);
                wl = 0;
            end
            if (!mem_ce_n && !prev_ce_n)
                chk(mem_addr == prev_addr, "R10 addr held", mem_addr, prev_addr);
            if (rd_valid) begin
                chk(!prev_valid, "R5 single valid", prev_valid, 0);
                chk(mem_ce_n, "R5 valid after access end", mem_ce_n, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected rd_valid", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R5 read data", rd_data, e);
                end
            end
            prev_ce_n = mem_ce_n;
            prev_addr = mem_addr;
            prev_valid = rd_valid;
        end
    end

    // Driver: called at a falling edge, waits for room, presents one request.
    task automatic issue(input bit we, input logic [15:0] a, input bit d);
        while (busy || ret_hold) @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        if (we) begin
            shadow[int'(a)] = d;
            last_wd = d;
        end else begin
            exp_q.push_back(peek(shadow, int'(a)));
        end
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        int acc0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(mem_ce_n == 1'b1, "R1 ce_n", mem_ce_n, 1);
        chk(mem_we_n == 1'b1, "R1 we_n", mem_we_n, 1);
        chk(mem_d == 1'b0, "R1 d", mem_d, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        mon_on = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && !busy && !rd_valid && !mem_d, "R1 after release", 0, 0);

        // Corner addresses, back-to-back writes then reads (R3 R4 R5 R8)
        issue(1, 16'h0000, 1);
        issue(1, 16'hFFFF, 1);
        issue(1, 16'h1234, 0);
        issue(1, 16'h5555, 1);
        issue(1, 16'hAAAA, 0);
        issue(0, 16'h0000, 0);
        issue(0, 16'hFFFF, 0);
        issue(0, 16'h1234, 0);
        issue(0, 16'h5555, 0);
        issue(0, 16'hAAAA, 0);
        issue(0, 16'h7777, 0);

        // Spread pattern with alternating direction
        for (int i = 0; i < 16; i++) begin
            issue(1, 16'(i * 4099), bit'(i[0] ^ i[2]));
            issue(0, 16'(i * 4099 + 1), 0);
        end
        for (int i = 0; i < 16; i++) issue(0, 16'(i * 4099), 0);

        // R2: a request offered while busy is ignored
        issue(1, 16'h0100, 1);
        acc0 = n_acc;
        chk(busy == 1'b1, "R2 busy during access", busy, 1);
        req = 1'b1; req_we = 1'b1; req_addr = 16'h0100; req_wdata = 1'b0;
        @(negedge clk);
        req = 1'b0;
        chk(n_acc == acc0, "R2 refused request", n_acc, acc0);
        issue(0, 16'h0100, 0);

        // R7: idle keeps the chip disabled
        repeat (12) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            if (mem_ce_n) cnt++;
            @(negedge clk);
        end
        chk(cnt == 8, "R7 idle standby", cnt, 8);

        // R9: retention hold and recovery window
        acc0 = n_acc;
        ret_hold = 1'b1; req = 1'b1; req_we = 1'b0; req_addr = 16'h0000;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(mem_ce_n == 1'b1, "R9 ce high in hold", mem_ce_n, 1);
        end
        ret_hold = 1'b0; req = 1'b0;
        chk(n_acc == acc0, "R9 no start in hold", n_acc, acc0);
        cnt = 0;
        while (busy && cnt < 50) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == P_RC, "R9 recovery length", cnt, P_RC);
        issue(0, 16'h0000, 0);
        issue(1, 16'hBEEF, 1);
        issue(0, 16'hBEEF, 0);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule